// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command front end of a byte-wide NOR flash array with a small behavioural storage model. A host drives the address and data buses and pulses an active-low write strobe. The block turns accepted bus writes into byte-program and sector-erase operations by matching multi-cycle unlock sequences. Each operation then runs for a fixed number of clock cycles, and the array is updated when that count ends.

While an operation is running, reads return status in place of array data. Bit 7 is the data-polling bit and bit 6 is a toggle bit. When the count ends, the block goes back to read mode. A program can only clear bits. An erase sets every byte of one sector back to all ones.

A read happens on each falling edge of the active-low output enable. A write is qualified by its strobe width and by the output enable being inactive.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After synchronous active-low reset, every array byte reads FFh and the block is in read mode.
- R2: A write is accepted only on the rising edge of `we_n`, only after `we_n` has been sampled low on at least MIN_WE_CYC clock edges, and only if `oe_n` is high at that rising edge. Any other strobe is ignored and does not advance the sequence.
- R3: Byte program is accepted after four writes: AAh at unlock address A, 55h at unlock address B, A0h at address A, then the data byte at the target address. Address A is 5555h and address B is 2AAAh, each compared on the low ADDR_W bits.
- R4: A program stores the old byte ANDed with the written data, so it never sets a bit.
- R5: Sector erase is accepted after six writes: AAh@A, 55h@B, 80h@A, AAh@A, 55h@B, then 30h at any address. The address of the last write selects the sector through bits [ADDR_W-1:SECT_W].
- R6: When an erase completes, every byte in the selected sector reads FFh, and bytes in other sectors are unchanged.
- R7: An operation stays busy for PROG_CYC clock cycles (program) or ERASE_CYC clock cycles (erase) after its last write is accepted. The block then returns to read mode with the array updated.
- R8: A read while busy returns bit 7 as the complement of bit 7 of the byte's final value, with bits 5:0 read as zero. For an erase, the final value is FFh.
- R9: The first read while busy after an operation starts returns bit 6 as 0, and bit 6 inverts on each further busy read.
- R10: A write that does not match the expected step returns the decoder to idle and does not change the array. A wrong erase code also leaves the array unchanged.
- R11: Writes accepted while an operation is busy are ignored.
- R12: `rd_data` is captured on the clock edge where a falling `oe_n` is seen, and it holds that value until the next such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address for writes and reads |
| bus_wdata | input | 8 | Write data |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable; each falling edge is one read |
| rd_data | output | 8 | Captured read data or busy status |

## Verification
Programming is tried with a fresh byte, a second program of the same byte, a byte at an unlock address, the top address, and an all-ones data byte. Together these separate a true AND from a plain overwrite, and show that unlock addresses hold no special meaning as targets. Status reads are taken while programming bytes whose final bit 7 is 1 and 0, and during an erase. This separates a correctly complemented polling bit from a stuck one and shows the toggle sequence. The erase uses an address deep inside one sector and then inspects neighbouring sectors. Broken sequences, short strobes, writes with output enable active, writes during busy and a wrong erase code each show that nothing changed, by reading back through the normal read port.

// File: rtl/flash_cmd_pkg.sv
// Package: command codes, unlock addresses and decoder state type shared
// by the flash command controller modules.
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_SETUP,
        SQ_UNL4,
        SQ_UNL5,
        SQ_PROG
    } seq_state_t;

    localparam logic [7:0]  CODE_UNL1  = 8'hAA;
    localparam logic [7:0]  CODE_UNL2  = 8'h55;
    localparam logic [7:0]  CODE_SETUP = 8'h80;
    localparam logic [7:0]  CODE_PROG  = 8'hA0;
    localparam logic [7:0]  CODE_ERASE = 8'h30;
    localparam logic [7:0]  BYTE_ERASED = 8'hFF;
    localparam logic [15:0] ADR_UNL_A  = 16'h5555;
    localparam logic [15:0] ADR_UNL_B  = 16'h2AAA;

endpackage

// File: rtl/flash_we_qual.sv
// Write strobe qualifier.
// Emits a one-cycle wr_stb on the cycle where a rising we_n is seen, provided
// we_n was sampled low on at least MIN_WE_CYC edges and oe_n is high.
// Assumes we_n and oe_n are synchronous to clk.
module flash_we_qual #(
    parameter int MIN_WE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_stb
);
    localparam int CNT_W = $clog2(MIN_WE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_WE_CYC);

    logic             we_q;
    logic [CNT_W-1:0] low_cnt;

    // Track the previous strobe level and count low cycles, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b1;
            low_cnt <= '0;
        end else begin
            we_q <= we_n;
            if (we_n)
                low_cnt <= '0;
            else if (low_cnt != CNT_MIN)
                low_cnt <= low_cnt + 1'b1;
        end
    end

    // Qualify the rising edge with pulse width and output enable.
    always_comb begin
        wr_stb = we_n && !we_q && oe_n && (low_cnt >= CNT_MIN);
    end

endmodule

// File: rtl/flash_seq_decode.sv
// Command sequence decoder.
// Walks the unlock/set-up steps on each qualified write. It pulses
// start_prog or start_erase in the cycle of the final write. Any mismatch
// returns to idle. Writes while busy are dropped. Assumes ADDR_W <= 16.
module flash_seq_decode #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              busy,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              start_prog,
    output logic              start_erase
);
    import flash_cmd_pkg::*;

    localparam logic [ADDR_W-1:0] ADR_A = ADR_UNL_A[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] ADR_B = ADR_UNL_B[ADDR_W-1:0];

    seq_state_t state, state_nxt;
    logic hit_a, hit_b;

    // Match the two unlock patterns on the current write.
    always_comb begin
        hit_a = (wr_addr == ADR_A) && (wr_data == CODE_UNL1);
        hit_b = (wr_addr == ADR_B) && (wr_data == CODE_UNL2);
    end

    // Next-state and start-pulse decode for one accepted write.
    always_comb begin
        state_nxt   = state;
        start_prog  = 1'b0;
        start_erase = 1'b0;
        if (busy) begin
            state_nxt = SQ_IDLE;
        end else if (wr_stb) begin
            case (state)
                SQ_IDLE:  state_nxt = hit_a ? SQ_UNL1 : SQ_IDLE;
                SQ_UNL1:  state_nxt = hit_b ? SQ_UNL2 : SQ_IDLE;
                SQ_UNL2: begin
                    if (wr_addr == ADR_A && wr_data == CODE_SETUP)
                        state_nxt = SQ_SETUP;
                    else if (wr_addr == ADR_A && wr_data == CODE_PROG)
                        state_nxt = SQ_PROG;
                    else
                        state_nxt = SQ_IDLE;
                end
                SQ_SETUP: state_nxt = hit_a ? SQ_UNL4 : SQ_IDLE;
                SQ_UNL4:  state_nxt = hit_b ? SQ_UNL5 : SQ_IDLE;
                SQ_UNL5: begin
                    state_nxt   = SQ_IDLE;
                    start_erase = (wr_data == CODE_ERASE);
                end
                SQ_PROG: begin
                    state_nxt  = SQ_IDLE;
                    start_prog = 1'b1;
                end
                default:  state_nxt = SQ_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nxt;
    end

endmodule

// File: rtl/flash_array.sv
// Behavioural byte array with sector granularity.
// Reset fills it with FFh. A program ANDs data into one byte, and an erase
// sets one sector to FFh. Both are single-cycle commit strobes. Read is
// combinational.
module flash_array #(
    parameter int ADDR_W = 10,
    parameter int SECT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_byte,
    input  logic                     prog_en,
    input  logic [ADDR_W-1:0]        prog_addr,
    input  logic [7:0]               prog_data,
    input  logic                     erase_en,
    input  logic [ADDR_W-SECT_W-1:0] erase_sect
);
    import flash_cmd_pkg::*;

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int SIDX_W = ADDR_W - SECT_W;

    logic [7:0] mem [DEPTH];

    // Apply reset fill, sector erase or byte program.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem[i] <= BYTE_ERASED;
            else if (erase_en && (erase_sect == SIDX_W'(i >> SECT_W)))
                mem[i] <= BYTE_ERASED;
            else if (prog_en && (prog_addr == ADDR_W'(i)))
                mem[i] <= mem[i] & prog_data;
        end
    end

    // Asynchronous read port.
    always_comb begin
        rd_byte = mem[rd_addr];
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
// Flash command sequence controller, top level.
// Qualifies bus writes, decodes program/erase sequences and times the busy
// phase with a cycle counter. Reads return array data, or polling and toggle
// status while busy. Assumes ERASE_CYC >= PROG_CYC >= 2 and ADDR_W <= 16.
module flash_cmd_ctrl #(
    parameter int ADDR_W     = 10,
    parameter int SECT_W     = 8,
    parameter int MIN_WE_CYC = 2,
    parameter int PROG_CYC   = 450,
    parameter int ERASE_CYC  = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              we_n,
    input  logic              oe_n,
    output logic [7:0]        rd_data
);
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int OPC_W   = $clog2(MAX_CYC);
    localparam logic [OPC_W-1:0] LIM_PROG  = OPC_W'(PROG_CYC - 1);
    localparam logic [OPC_W-1:0] LIM_ERASE = OPC_W'(ERASE_CYC - 1);

    logic              wr_stb;
    logic              start_prog, start_erase;
    logic              busy, op_is_erase, op_done, tog, oe_q, rd_fire, exp7;
    logic [ADDR_W-1:0] op_addr, arr_addr;
    logic [7:0]        op_data, arr_byte;
    logic [OPC_W-1:0]  op_cnt;

    flash_we_qual #(.MIN_WE_CYC(MIN_WE_CYC)) u_qual (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .oe_n(oe_n), .wr_stb(wr_stb)
    );

    flash_seq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .busy(busy),
        .wr_addr(bus_addr), .wr_data(bus_wdata),
        .start_prog(start_prog), .start_erase(start_erase)
    );

    flash_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(arr_addr), .rd_byte(arr_byte),
        .prog_en(op_done && !op_is_erase), .prog_addr(op_addr), .prog_data(op_data),
        .erase_en(op_done && op_is_erase), .erase_sect(op_addr[ADDR_W-1:SECT_W])
    );

    // Busy-phase end detection and array read address selection.
    always_comb begin
        op_done  = busy && (op_cnt == (op_is_erase ? LIM_ERASE : LIM_PROG));
        arr_addr = busy ? op_addr : bus_addr;
        exp7     = op_is_erase ? 1'b1 : (arr_byte[7] & op_data[7]);
        rd_fire  = oe_q && !oe_n;
    end

    // Operation latch and busy timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            op_is_erase <= 1'b0;
            op_addr     <= '0;
            op_data     <= '0;
            op_cnt      <= '0;
        end else if (start_prog || start_erase) begin
            busy        <= 1'b1;
            op_is_erase <= start_erase;
            op_addr     <= bus_addr;
            op_data     <= bus_wdata;
            op_cnt      <= '0;
        end else if (op_done) begin
            busy <= 1'b0;
        end else if (busy) begin
            op_cnt <= op_cnt + 1'b1;
        end
    end

    // Read capture with polling/toggle status while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q    <= 1'b1;
            tog     <= 1'b0;
            rd_data <= '0;
        end else begin
            oe_q <= oe_n;
            if (start_prog || start_erase) begin
                tog <= 1'b0;
            end else if (rd_fire) begin
                if (busy) begin
                    rd_data <= {~exp7, tog, 6'b0};
                    tog     <= ~tog;
                end else begin
                    rd_data <= arr_byte;
                end
            end
        end
    end

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
// Checker for flash_cmd_ctrl, attached by bind.
// Assumes MAX_BUSY is the longest operation length in cycles.
module flash_cmd_ctrl_chk #(
    parameter int MAX_BUSY = 2000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       busy,
    input logic       start_prog,
    input logic       start_erase,
    input logic [7:0] rd_data
);
    int busy_run;

    // Count consecutive busy cycles for the length bound.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_run <= 0;
        else                 busy_run <= busy_run + 1;
    end

    // R1: reset leaves the block idle.
    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !busy);

    // R2: an operation only starts on a released strobe with output enable high.
    a_r2_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog || start_erase) |-> (we_n && oe_n));

    // R11: no new operation while busy.
    a_r11_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(start_prog || start_erase));

    // R7: the busy phase never outlasts the longest operation.
    a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= MAX_BUSY);

    // R12: read data holds unless a falling output enable was seen.
    a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(oe_n) |=> $stable(rd_data));

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.MAX_BUSY(ERASE_CYC)) u_chk (.*);

// File: tb/flash_cmd_ctrl_bench.sv
// Testbench for flash_cmd_ctrl: table-driven program checks, then directed
// tests for status reads, erase, and ignored writes.
module flash_cmd_ctrl_bench;
    localparam int ADDR_W    = 10;
    localparam int PROG_CYC  = 450;
    localparam int ERASE_CYC = 2000;
    localparam logic [ADDR_W-1:0] UA = 10'h155;
    localparam logic [ADDR_W-1:0] UB = 10'h2AA;

    // {address, data, expected byte after program}
    localparam logic [25:0] VEC [6] = '{
        {10'h010, 8'hA5, 8'hA5},
        {10'h010, 8'h3C, 8'h24},
        {10'h155, 8'h0F, 8'h0F},
        {10'h3FF, 8'h00, 8'h00},
        {10'h100, 8'hF0, 8'hF0},
        {10'h100, 8'hFF, 8'hF0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              we_n = 1'b1;
    logic              oe_n = 1'b1;
    logic [7:0]        rd_data;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC))
        u_flash_cmd_ctrl (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
                          .bus_wdata(bus_wdata), .we_n(we_n), .oe_n(oe_n),
                          .rd_data(rd_data));

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                      input int low = 2, input logic oe = 1'b1);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; oe_n = oe; we_n = 1'b0;
        repeat (low) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        oe_n = 1'b1;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; oe_n = 1'b0;
        @(negedge clk);
        v = rd_data;
        oe_n = 1'b1;
    endtask

    task automatic unlock();
        wr(UA, 8'hAA);
        wr(UB, 8'h55);
    endtask

    task automatic prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        unlock();
        wr(UA, 8'hA0);
        wr(a, d);
    endtask

    task automatic erase_cmd(input logic [ADDR_W-1:0] a, input logic [7:0] code);
        unlock();
        wr(UA, 8'h80);
        unlock();
        wr(a, code);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: erased array after reset
        rd(10'h000, v); check("R1 reset byte 000", v, 8'hFF);
        rd(10'h3FF, v); check("R1 reset byte 3FF", v, 8'hFF);

        // R3 R4: table of program operations
        for (int i = 0; i < 6; i++) begin
            prog(VEC[i][25:16], VEC[i][15:8]);
            repeat (PROG_CYC + 4) @(negedge clk);
            rd(VEC[i][25:16], v);
            check($sformatf("R3/R4 vector %0d", i), v, VEC[i][7:0]);
        end

        // R8 R9 R7: status while programming 80h (final bit7 = 1)
        prog(10'h050, 8'h80);
        rd(10'h000, v); check("R8 poll bit7 first read", v, 8'h00);
        rd(10'h000, v); check("R9 toggle second read", v, 8'h40);
        rd(10'h000, v); check("R9 toggle third read", v, 8'h00);
        repeat (PROG_CYC - 40) @(negedge clk);
        rd(10'h050, v); check("R7 still busy near end", v, 8'h40);
        repeat (40) @(negedge clk);
        rd(10'h050, v); check("R7 read mode after program", v, 8'h80);

        // R8 R11: final bit7 = 0, writes during busy ignored
        prog(10'h051, 8'h12);
        rd(10'h000, v); check("R8 poll bit7 for zero bit", v, 8'h80);
        prog(10'h052, 8'h00);
        repeat (PROG_CYC + 4) @(negedge clk);
        rd(10'h051, v); check("R11 first program landed", v, 8'h12);
        rd(10'h052, v); check("R11 busy-time program ignored", v, 8'hFF);

        // R2: short strobe ignored, decoder still waiting for data
        unlock(); wr(UA, 8'hA0);
        wr(10'h060, 8'h00, 1);
        rd(10'h060, v); check("R2 short strobe not started", v, 8'hFF);
        wr(10'h060, 8'h33);
        repeat (PROG_CYC + 4) @(negedge clk);
        rd(10'h060, v); check("R2 later full strobe programs", v, 8'h33);

        // R2: write with output enable active ignored
        unlock(); wr(UA, 8'hA0);
        wr(10'h061, 8'h44, 2, 1'b0);
        rd(10'h061, v); check("R2 oe-low write not started", v, 8'hFF);
        wr(10'h061, 8'h0F);
        repeat (PROG_CYC + 4) @(negedge clk);
        rd(10'h061, v); check("R2 oe-low data not used", v, 8'h0F);

        // R10: broken sequences
        unlock(); wr(UA, 8'h77);
        wr(10'h062, 8'h00);
        repeat (PROG_CYC + 4) @(negedge clk);
        rd(10'h062, v); check("R10 wrong code aborts", v, 8'hFF);
        wr(UA, 8'hAA); wr(10'h001, 8'h55); wr(UA, 8'hA0); wr(10'h063, 8'h00);
        repeat (PROG_CYC + 4) @(negedge clk);
        rd(10'h063, v); check("R10 wrong address aborts", v, 8'hFF);

        // R10: wrong erase code leaves sector 1
        erase_cmd(10'h120, 8'h20);
        repeat (ERASE_CYC + 4) @(negedge clk);
        rd(10'h100, v); check("R10 bad erase code no change", v, 8'hF0);

        // R5 R6 R8: erase sector 0 through address 020h, poll to completion
        erase_cmd(10'h020, 8'h30);
        rd(10'h020, v); check("R8 erase poll bit7", v, 8'h00);
        for (int k = 0; k < ERASE_CYC; k++) begin
            rd(10'h020, v);
            if (v[7]) break;
        end
        check("R7 erase poll ends with FF", v, 8'hFF);
        rd(10'h010, v); check("R6 sector 0 byte 010 erased", v, 8'hFF);
        rd(10'h050, v); check("R5 sector 0 byte 050 erased", v, 8'hFF);
        rd(10'h100, v); check("R6 sector 1 byte 100 kept", v, 8'hF0);
        rd(10'h155, v); check("R6 sector 1 byte 155 kept", v, 8'h0F);
        rd(10'h3FF, v); check("R6 sector 3 byte 3FF kept", v, 8'h00);

        // R12: data held while oe_n stays low and address moves
        @(negedge clk); bus_addr = 10'h100; oe_n = 1'b0;
        @(negedge clk); bus_addr = 10'h000;
        repeat (3) @(negedge clk);
        check("R12 rd_data held", rd_data, 8'hF0);
        oe_n = 1'b1;

        // R1: reset again restores erased array
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(10'h3FF, v); check("R1 re-reset byte 3FF", v, 8'hFF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule